// File: doc/BRIEF.md
# Temperature Alert Status Logic

This block watches two temperature readings and flags out-of-range values. The local reading is 8 bits wide and is tested against a one-byte high limit and a one-byte low limit. The remote reading is 16 bits wide and is tested against limits built from two bytes each. The remote open-circuit indication is tested as a fifth condition. Each condition passes through a consecutive-sample filter before it can raise an alarm. Each of the five conditions counts its own run of violating samples.

A qualified condition sets a sticky bit in a read-only status byte. A host reads that byte through a small register port. The same port sets the limits, the configuration byte and the filter setting. Reading the status byte clears only the bits whose condition has gone away. A bit whose condition is still present stays set.

The active-low alert output latches when any condition qualifies and alerts are enabled. It then stays asserted through any status read. It releases only when the host side pulses the alert-serviced input.

Top module: `temp_alert_status`

## Requirements
- R1: After reset the limit registers read local-high 55h, local-low 00h, remote-high MS 55h, remote-high LS 00h, and both remote-low bytes 00h. The configuration and filter registers read 00h, the status byte reads 00h, and alert_n is 1.
- R2: A high violation is a reading strictly greater than its high limit. A low violation is a reading strictly less than its low limit. The remote reading is compared as 16 bits against {MS,LS}.
- R3: The filter register field [2:0] selects how many consecutive violating samples are needed: 000=1, 001=2, 011=3, 111=4. Every other code acts as 1.
- R4: Any in-limit sample resets that condition's run count to zero. A violation needs a fresh consecutive run after that.
- R5: The status byte (address 0) has this layout: bit7 is conv_busy, live and not sticky. Bit6 is local high, bit5 local low, bit4 remote high, bit3 remote low, bit2 remote open. Bits 1:0 read 0.
- R6: A write to address 0 changes nothing.
- R7: A status read clears each flag whose most recent sample was in limit. It keeps each flag whose condition still held at the most recent sample. The read itself returns the value from before the clear.
- R8: alert_n goes low in the cycle after a qualifying sample. It stays low through status reads until an alert_ack pulse.
- R9: Configuration bit 5 enables the alert. While it is 0, alert_n stays 1 but the status flags still update.
- R10: remote_open, once it qualifies, sets status bit 2 and drives alert_n low.

Register addresses: 0 status, 1 configuration, 2 filter, 3 local high, 4 local low, 5 remote-high MS, 6 remote-high LS, 7 remote-low MS, 8 remote-low LS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_valid | input | 1 | New readings are valid this cycle |
| local_temp | input | 8 | Local zone reading |
| remote_temp | input | 16 | Remote zone reading |
| remote_open | input | 1 | Remote sensor open-circuit indication |
| conv_busy | input | 1 | Conversion in progress |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | AW | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data (combinational) |
| alert_ack | input | 1 | Host has serviced the alert |
| alert_n | output | 1 | Active-low alert |

## Verification
Assertions check four rules on every cycle:
- alert_n holds low until alert_ack arrives.
- A disabled alert never drives low.
- Status flags only rise on a sample strobe.
- A write to the status address leaves the flags untouched.

Only the bench scenarios can show the rest, because each depends on a chosen sequence of readings and settings:
- the strict boundary of each comparison;
- the mapping from each filter code to a run length;
- a run broken by an in-limit sample;
- the selective clearing of flags on a status read.

// File: rtl/temp_alert_status.sv
module temp_alert_status #(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_valid,
  input  logic [7:0]    local_temp,
  input  logic [15:0]   remote_temp,
  input  logic          remote_open,
  input  logic          conv_busy,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata,
  input  logic          alert_ack,
  output logic          alert_n
);
  localparam int NC = 5;
  localparam logic [AW-1:0] A_STAT = AW'(0), A_CFG = AW'(1), A_FILT = AW'(2),
    A_LHI = AW'(3), A_LLO = AW'(4), A_RHM = AW'(5), A_RHL = AW'(6),
    A_RLM = AW'(7), A_RLL = AW'(8);

  logic [7:0]    cfg_q, lhi_q, llo_q, rhm_q, rhl_q, rlm_q, rll_q;
  logic [2:0]    filt_q, need;
  logic [NC-1:0] cond, qual, present, flag_q, clr_mask;
  logic          alert_q, stat_rd;

  always_comb begin
    case (filt_q)
      3'b001:  need = 3'd2;
      3'b011:  need = 3'd3;
      3'b111:  need = 3'd4;
      default: need = 3'd1;
    endcase
  end

  assign cond = {local_temp > lhi_q, local_temp < llo_q,
                 remote_temp > {rhm_q, rhl_q}, remote_temp < {rlm_q, rll_q},
                 remote_open};

  for (genvar i = 0; i < NC; i++) begin : g_run
    logic [2:0] cnt_q, cnt_nx;
    assign cnt_nx     = !cond[i] ? 3'd0 : (cnt_q == 3'd4) ? 3'd4 : cnt_q + 3'd1;
    assign qual[i]    = smp_valid && cond[i] && (cnt_nx >= need);
    assign present[i] = (cnt_q != 3'd0);
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)         cnt_q <= 3'd0;
      else if (smp_valid) cnt_q <= cnt_nx;
  end

  assign stat_rd  = rd_en && (addr == A_STAT);
  assign clr_mask = stat_rd ? ~present : '0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) flag_q <= '0;
    else        flag_q <= (flag_q & ~clr_mask) | qual;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                   alert_q <= 1'b0;
    else if (|qual && cfg_q[5])   alert_q <= 1'b1;
    else if (alert_ack)           alert_q <= 1'b0;

  assign alert_n = ~(alert_q & cfg_q[5]);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cfg_q <= 8'h00; filt_q <= 3'b000;
      lhi_q <= 8'h55; llo_q <= 8'h00;
      rhm_q <= 8'h55; rhl_q <= 8'h00; rlm_q <= 8'h00; rll_q <= 8'h00;
    end else if (wr_en) begin
      case (addr)
        A_CFG:  cfg_q  <= wdata;
        A_FILT: filt_q <= wdata[2:0];
        A_LHI:  lhi_q  <= wdata;
        A_LLO:  llo_q  <= wdata;
        A_RHM:  rhm_q  <= wdata;
        A_RHL:  rhl_q  <= wdata;
        A_RLM:  rlm_q  <= wdata;
        A_RLL:  rll_q  <= wdata;
        default: ;
      endcase
    end

  always_comb begin
    case (addr)
      A_STAT:  rdata = {conv_busy, flag_q, 2'b00};
      A_CFG:   rdata = cfg_q;
      A_FILT:  rdata = {5'b0, filt_q};
      A_LHI:   rdata = lhi_q;
      A_LLO:   rdata = llo_q;
      A_RHM:   rdata = rhm_q;
      A_RHL:   rdata = rhl_q;
      A_RLM:   rdata = rlm_q;
      A_RLL:   rdata = rll_q;
      default: rdata = 8'h00;
    endcase
  end

  AST_ALERT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!alert_n && !alert_ack && cfg_q[5] && !(wr_en && addr == A_CFG)) |=> !alert_n); // R8
  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_q[5] |-> alert_n); // R9
  AST_FLAG_ON_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    ((flag_q & ~$past(flag_q)) != '0) |-> $past(smp_valid)); // R3
  AST_STATUS_WRITE_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_STAT && !rd_en && !smp_valid) |=> $stable(flag_q)); // R6
endmodule

// File: tb/sim_temp_alert_status.sv
module sim_temp_alert_status;
  localparam time CLK_PERIOD = 10ns;
  localparam int AW = 4;

  logic clk = 0, rst_n = 0, smp_valid = 0, remote_open = 0, conv_busy = 0;
  logic wr_en = 0, rd_en = 0, alert_ack = 0, alert_n;
  logic [7:0] local_temp = 0, wdata = 0, rdata;
  logic [15:0] remote_temp = 0;
  logic [AW-1:0] addr = 0;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  temp_alert_status #(.AW(AW)) u0 (.clk, .rst_n, .smp_valid, .local_temp, .remote_temp,
    .remote_open, .conv_busy, .wr_en, .rd_en, .addr, .wdata, .rdata, .alert_ack, .alert_n);

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; addr = AW'(a); wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input int a, output logic [7:0] v);
    @(negedge clk); rd_en = 1; addr = AW'(a); #1 v = rdata;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic smp(input logic [7:0] lt, input logic [15:0] rt, input logic op);
    @(negedge clk); smp_valid = 1; local_temp = lt; remote_temp = rt; remote_open = op;
    @(negedge clk); smp_valid = 0;
  endtask

  task automatic ack();
    @(negedge clk); alert_ack = 1;
    @(negedge clk); alert_ack = 0;
  endtask

  task automatic tidy();
    logic [7:0] v;
    smp(8'd30, 16'h3000, 1'b0);
    rd(0, v);
    ack();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v, hold;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset values
    rd(0, v); chk("R1 status", v, 8'h00);
    rd(1, v); chk("R1 cfg", v, 8'h00);
    rd(2, v); chk("R1 filt", v, 8'h00);
    rd(3, v); chk("R1 lhi", v, 8'h55);
    rd(4, v); chk("R1 llo", v, 8'h00);
    rd(5, v); chk("R1 rhm", v, 8'h55);
    rd(6, v); chk("R1 rhl", v, 8'h00);
    rd(7, v); chk("R1 rlm", v, 8'h00);
    rd(8, v); chk("R1 rll", v, 8'h00);
    chk("R1 alert_n", alert_n, 1);

    wr(1, 8'h20); wr(3, 8'd40); wr(4, 8'd10);
    // R2 local sweep, 1-sample filter
    for (int t = 0; t < 128; t++) begin
      smp(8'(t), 16'h3000, 1'b0);
      rd(0, v);
      chk("R2 local cmp", v, ((t > 40) ? 8'h40 : 8'h00) | ((t < 10) ? 8'h20 : 8'h00));
      tidy();
    end
    // R2 remote 16-bit boundaries
    wr(7, 8'h10); wr(8, 8'h80);
    smp(8'd30, 16'h5500, 1'b0); rd(0, v); chk("R2 rhi equal", v, 8'h00); tidy();
    smp(8'd30, 16'h5501, 1'b0); rd(0, v); chk("R2 rhi over", v, 8'h10); tidy();
    smp(8'd30, 16'h1080, 1'b0); rd(0, v); chk("R2 rlo equal", v, 8'h00); tidy();
    smp(8'd30, 16'h107F, 1'b0); rd(0, v); chk("R2 rlo under", v, 8'h08); tidy();

    // R3 filter encodings, all eight codes
    for (int e = 0; e < 8; e++) begin
      n = (e == 1) ? 2 : (e == 3) ? 3 : (e == 7) ? 4 : 1;
      wr(2, 8'(e)); tidy();
      for (int k = 1; k <= 4; k++) begin
        smp(8'd60, 16'h3000, 1'b0);
        rd(0, v);
        chk("R3 filt flag", v[6], (k >= n) ? 1 : 0);
        chk("R8 alert after run", alert_n, (k >= n) ? 0 : 1);
      end
      tidy();
    end

    // R4 broken run with 3-sample filter
    wr(2, 8'h03); tidy();
    smp(8'd60, 16'h3000, 1'b0); smp(8'd60, 16'h3000, 1'b0);
    smp(8'd30, 16'h3000, 1'b0);
    smp(8'd60, 16'h3000, 1'b0); smp(8'd60, 16'h3000, 1'b0);
    rd(0, v); chk("R4 run reset", v[6], 0);
    smp(8'd60, 16'h3000, 1'b0);
    rd(0, v); chk("R4 third in run", v[6], 1);
    wr(2, 8'h00); tidy();

    // R5 busy live, reserved zero
    conv_busy = 1; rd(0, v); chk("R5 busy bit", v, 8'h80);
    conv_busy = 0; rd(0, v); chk("R5 busy clears", v, 8'h00);

    // R10 open circuit, R7 selective clear
    smp(8'd60, 16'h3000, 1'b1);
    rd(0, v); chk("R10 open+hi flags", v, 8'h44);
    chk("R10 alert", alert_n, 0);
    smp(8'd30, 16'h3000, 1'b1);
    rd(0, v); chk("R7 read shows pre-clear", v, 8'h44);
    rd(0, v); chk("R7 keeps present", v, 8'h04);
    // R8 latched through reads until ack
    chk("R8 alert held", alert_n, 0);
    // R6 write to status ignored
    hold = v; wr(0, 8'hFF); rd(0, v); chk("R6 write ignored", v, hold);
    ack(); chk("R8 alert released", alert_n, 1);
    smp(8'd30, 16'h3000, 1'b0); rd(0, v); rd(0, v); chk("R7 clears absent", v, 8'h00);
    ack();

    // R9 disabled alert, status still updates
    wr(1, 8'h00);
    smp(8'd60, 16'h3000, 1'b0);
    rd(0, v); chk("R9 status updates", v, 8'h40);
    chk("R9 alert quiet", alert_n, 1);
    tidy();

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule